// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory. An external address is captured on a rising clock edge when either of two address-strobe inputs is high. One strobe serves the processor side and the other the memory-controller side. The captured address is the first beat of a four-beat burst. Each later cycle with the advance input high steps to the next beat. The two low address bits then follow one of two orders, chosen by a static mode input. The upper bits stay fixed for the whole burst.

A caller that does not want bursts strobes a new address on every cycle. A load is never delayed and never costs a cycle, so bursting is optional. No data stream passes through this block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status pin, sampled or updated on the rising edge of `clk`.

The mode encoding is 1 for linear and 0 for interleaved. A mode pin that is tied low or left at its default therefore selects interleaved order.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `word_addr` is 0 and `burst_active` is 0.
- R2: When `strobe_cpu` or `strobe_ctl` is high at a rising edge, `word_addr` equals the sampled `ext_addr` from the next cycle on, and `burst_active` is 1.
- R3: While `burst_active` is 1, each rising edge with `advance` high and no strobe moves the burst to the next beat (beat n becomes n+1).
- R4: At a rising edge with no strobe and `advance` low, `word_addr` and `burst_active` keep their values, provided `order_linear` does not change.
- R5: With `order_linear` = 1, the two low bits of `word_addr` at beat n equal (start low bits + n) mod 4.
- R6: With `order_linear` = 0, the two low bits of `word_addr` at beat n equal the start low bits XOR n.
- R7: Bits above the two low bits of `word_addr` equal those of the captured address for the whole burst.
- R8: When a strobe and `advance` are both high at the same edge, the strobe wins: the new address is loaded at beat 0.
- R9: An advance at beat 3 ends the burst. `burst_active` drops to 0 and `word_addr` holds the beat-3 address. Advances while `burst_active` is 0 have no effect on `word_addr`.
- R10: A strobe on every consecutive cycle loads every address, each one visible on the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu | input | 1 | Processor-side address strobe; loads `ext_addr` |
| strobe_ctl | input | 1 | Controller-side address strobe; loads `ext_addr` |
| advance | input | 1 | Step to the next burst beat |
| order_linear | input | 1 | Burst order: 1 = linear wrap, 0 = interleaved (XOR) |
| ext_addr | input | ADDR_W | External start address |
| word_addr | output | ADDR_W | Current word address |
| burst_active | output | 1 | Beats remain in the current burst |

## Verification
The assertions check on every cycle that a strobe captures the address and raises the active flag. They also check that a strobe overrides a concurrent advance, that the beat moves by exactly one per accepted advance, that idle cycles leave the beat and base untouched, and that the upper address bits stay fixed between loads. The exact low-bit sequences of the two orderings need the bench's reference model, checked over bursts that start at several low-bit offsets. So do the end of a burst and the ignored advances after it, back-to-back strobes on alternating strobe pins, and the reset values.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q)); // R7

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat,
  output logic              active
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  logic at_last;
  assign at_last = (beat == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat   <= '0;
      active <= 1'b0;
    end else if (load) begin
      beat   <= '0;
      active <= 1'b1;
    end else if (adv && active) begin
      if (at_last) begin
        active <= 1'b0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && adv) |=> (beat == '0) && active); // R8

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && active && !at_last) |=> (beat == $past(beat) + 1'b1) && active); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(beat) && $stable(active)); // R4

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv && active && at_last) |=> !active && $stable(beat)); // R9

  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !active) |=> !active && $stable(beat)); // R9

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] lo_out
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign lin_lo = start_lo + beat;

  for (genvar gi = 0; gi < BEAT_W; gi++) begin : g_ilv
    assign ilv_lo[gi] = start_lo[gi] ^ beat[gi];
  end

  always_comb begin
    lo_out = (order == ORD_LINEAR) ? lin_lo : ilv_lo;
  end

  always_comb begin
    if (beat == '0) begin
      assert (lo_out == start_lo); // R2
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_linear,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic              burst_active
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lo_bits;
  burst_order_e      order;

  assign load  = strobe_cpu | strobe_ctl;
  assign order = burst_order_e'(order_linear);

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .addr_in (ext_addr),
    .base_q  (base_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .adv    (advance),
    .beat   (beat),
    .active (burst_active)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo (base_q[BEAT_W-1:0]),
    .beat     (beat),
    .order    (order),
    .lo_out   (lo_bits)
  );

  assign word_addr = {base_q[ADDR_W-1:BEAT_W], lo_bits};

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_addr == $past(ext_addr)) && burst_active); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_addr[ADDR_W-1:BEAT_W])); // R7

  AST_HI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_addr[ADDR_W-1:ADDR_W-HI_W] == $past(ext_addr[ADDR_W-1:ADDR_W-HI_W]))); // R7

endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe_cpu, strobe_ctl, advance, order_linear;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] word_addr;
  logic          burst_active;

  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] m_base;
  int            m_beat;
  bit            m_act;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .advance(advance), .order_linear(order_linear), .ext_addr(ext_addr),
    .word_addr(word_addr), .burst_active(burst_active)
  );

  function automatic logic [AW-1:0] model_addr();
    int lo;
    int s;
    s = int'(m_base[1:0]);
    if (order_linear) lo = (s + m_beat) % 4;
    else              lo = s ^ m_beat;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] e;
    e = model_addr();
    n_tests++;
    if (word_addr !== e || burst_active !== m_act) begin
      n_fail++;
      $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0b",
               tag, word_addr, burst_active, e, m_act);
    end
  endtask

  task automatic cyc(input bit sc, input bit sl, input bit adv,
                     input logic [AW-1:0] a, input string tag);
    strobe_cpu = sc; strobe_ctl = sl; advance = adv; ext_addr = a;
    @(posedge clk);
    if (sc || sl) begin
      m_base = a; m_beat = 0; m_act = 1'b1;
    end else if (adv && m_act) begin
      if (m_beat == 3) m_act = 1'b0;
      else m_beat++;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe_cpu = 0; strobe_ctl = 0; advance = 0;
    order_linear = 1'b0; ext_addr = '0;
    m_base = '0; m_beat = 0; m_act = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    cyc(0, 0, 0, 24'h0, "R1 after reset");

    // Linear burst starting at low bits 2
    order_linear = 1'b1;
    cyc(1, 0, 0, 24'hABCDE6, "R2 cpu strobe load");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 24'h0, "R5 linear beat / R3");
    n_tests++;
    if (word_addr[AW-1:2] !== 22'(24'hABCDE6 >> 2)) begin
      n_fail++;
      $display("FAIL R7: hi=%h expected %h", word_addr[AW-1:2], 22'(24'hABCDE6 >> 2));
    end
    cyc(0, 0, 1, 24'h0, "R9 burst end");
    cyc(0, 0, 1, 24'h0, "R9 advance ignored");
    cyc(0, 0, 1, 24'h123456, "R9 advance ignored, addr bus busy");

    // Interleaved burst starting at low bits 1, with stalls
    order_linear = 1'b0;
    cyc(0, 1, 0, 24'h00F0F1, "R2 ctl strobe load");
    cyc(0, 0, 1, 24'h0, "R6 interleave beat 1");
    cyc(0, 0, 0, 24'hFFFFFF, "R4 stall");
    cyc(0, 0, 0, 24'h0, "R4 stall");
    cyc(0, 0, 1, 24'h0, "R6 interleave beat 2");
    cyc(0, 0, 1, 24'h0, "R6 interleave beat 3");
    cyc(0, 0, 1, 24'h0, "R9 end interleave");

    // Interleaved from low bits 3 and linear from low bits 3
    cyc(1, 0, 0, 24'h765433, "R2 load lo=3");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 24'h0, "R6 interleave lo=3");
    order_linear = 1'b1;
    cyc(1, 1, 0, 24'h765433, "R2 both strobes");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 24'h0, "R5 linear lo=3");

    // Strobe with advance in the same cycle
    cyc(0, 1, 0, 24'h111110, "R2 load");
    cyc(0, 0, 1, 24'h0, "R3 step");
    cyc(1, 0, 1, 24'h222222, "R8 strobe beats advance");
    cyc(0, 1, 1, 24'h333331, "R8 strobe beats advance ctl");
    cyc(0, 0, 1, 24'h0, "R5 step after R8 load");

    // Back-to-back loads alternating strobes
    for (int i = 0; i < 8; i++)
      cyc((i % 2) == 0, (i % 2) == 1, i[0], 24'h400000 + 24'(i * 37), "R10 back-to-back load");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 24'h0, "R5 tail");

    // Reset in the middle of a burst
    cyc(1, 0, 0, 24'h5A5A5A, "R2 load before reset");
    rst_n = 1'b0;
    m_base = '0; m_beat = 0; m_act = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-burst");
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule